// File: doc/BRIEF.md
# Serially Loaded Content Addressable Memory

This block is a content addressable memory. A caller gives it a data word and gets back the index of the stored entry that holds that word. Storage is split into banks of sixteen entries. Each entry keeps one 16-bit one-hot lookup table for every 4-bit slice of the word. A search uses each key slice to index its table and ANDs the table outputs across the word. All entries are compared in a single cycle, and the block registers the resulting decoded hit vector.

One cycle later, a registered encoder turns the hit vector into a binary entry index and a found flag. The upper index bits name the bank that hit and the lower four bits give the position inside that bank. Adding banks widens the comparison but does not add match latency.

A store takes sixteen clocks. A nibble counter steps down from 15 to 0. On each step, every table of the target entry shifts in a 1 if the counter equals its data slice and a 0 if it does not. While a store runs, the block raises `busy` and performs no search. A requester keeps `match_req` asserted until the block accepts it.

Top module: `shift_cam`

## Requirements
- R1: After reset, `busy`, `hit_valid`, `addr_valid` and `match_found` are low, and no entry matches any key until it has been written.
- R2: A write is accepted on a clock edge where `wr_req` is high and `busy` is low; `busy` is then high for exactly 16 cycles.
- R3: A `wr_req` presented while `busy` is high is ignored: its address and data are never stored, and the load in progress completes with its own data.
- R4: A search is performed only on an edge where `match_req` is high and `busy` is low; when `busy` is high, `hit_valid` is low in the following cycle.
- R5: One cycle after an accepted search, `hit_valid` is high and `hit_vec` bit i is 1 exactly when entry i has been written and holds a word equal to the key; `hit_vec` holds its value until the next accepted search.
- R6: One cycle after `hit_valid`, `addr_valid` is high and `match_found` and `match_addr` reflect that hit vector; both hold until the next encoder update.
- R7: When several entries hit, `match_addr` is the lowest index among them.
- R8: When no entry hits, `match_found` is low and `match_addr` is 0.
- R9: Writing an entry that already holds a word replaces it completely, so the old word no longer hits there.
- R10: `match_addr` bits [ADDR_W-1:4] are the bank number and bits [3:0] are the position inside that bank, for entries in any bank.
- R11: If a search and a write are accepted on the same edge, the search sees the contents as they were before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Start a store when the block is idle |
| wr_addr | input | ADDR_W | Entry index to store into |
| wr_data | input | DATA_W | Word to store |
| busy | output | 1 | A store is in progress |
| match_req | input | 1 | Request a search |
| match_key | input | DATA_W | Word to search for |
| hit_valid | output | 1 | `hit_vec` was updated on the last edge |
| hit_vec | output | 2**ADDR_W | Decoded per-entry hit vector |
| addr_valid | output | 1 | `match_found` and `match_addr` were updated on the last edge |
| match_found | output | 1 | At least one entry hit |
| match_addr | output | ADDR_W | Lowest hitting entry index |

## Verification
Searches are run against an empty memory, against a single stored word, and against duplicate words placed in both banks. These cases separate a missing-hit fault, a wrong bank prefix and a wrong lowest-index choice. The word 0x00 is stored on purpose, so that a valid zero entry can be told apart from an unwritten one. A run of random stores and searches over a small value set produces frequent overwrites and collisions. Searches are also issued while a store is running and on the same edge a store starts, which exposes any mistake in hold-off or ordering.

// File: rtl/shift_cam_pkg.sv
package shift_cam_pkg;
   localparam int BANK_ENTRIES = 16;
   localparam int SLICE_W      = 4;

   function automatic logic [3:0] lowest16(input logic [15:0] v);
      logic [3:0] idx;
      idx = 4'd0;
      for (int i = 15; i >= 0; i--) begin
         if (v[i]) idx = 4'(i);
      end
      return idx;
   endfunction
endpackage

// File: rtl/cam_slice_table.sv
module cam_slice_table (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       shift_en,
   input  logic       shift_bit,
   input  logic [3:0] look_key,
   output logic       look_hit
);
   logic [15:0] tbl;

   always_ff @(posedge clk) begin
      if (!rst_n)        tbl <= '0;
      else if (shift_en) tbl <= {tbl[14:0], shift_bit};
   end

   assign look_hit = tbl[look_key];
endmodule

// File: rtl/cam_load_seq.sv
module cam_load_seq #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic [3:0]        step,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [DATA_W-1:0] tgt_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         step     <= 4'd0;
         tgt_addr <= '0;
         tgt_data <= '0;
      end else if (busy) begin
         if (step == 4'd0) busy <= 1'b0;
         else              step <= step - 4'd1;
      end else if (wr_req) begin
         busy     <= 1'b1;
         step     <= 4'd15;
         tgt_addr <= wr_addr;
         tgt_data <= wr_data;
      end
   end

   // R3: a load in progress keeps its own target
   p_hold_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(tgt_addr) && $stable(tgt_data)));
   // R2: a load always starts at the top nibble value
   p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (step == 4'd15));
   // R2: the load ends after the last nibble value
   p_load_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step == 4'd0) |=> !busy);
endmodule

// File: rtl/cam_bank16.sv
module cam_bank16 #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [3:0]        ld_slot,
   input  logic [3:0]        ld_step,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [DATA_W-1:0] key,
   output logic [15:0]       hit
);
   localparam int NSLICE = DATA_W / shift_cam_pkg::SLICE_W;

   for (genvar e = 0; e < shift_cam_pkg::BANK_ENTRIES; e++) begin : g_entry
      logic [NSLICE-1:0] slice_hit;
      logic              sel;
      assign sel = ld_en && (ld_slot == 4'(e));
      for (genvar n = 0; n < NSLICE; n++) begin : g_slice
         cam_slice_table u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (sel),
            .shift_bit(ld_step == ld_data[n*4 +: 4]),
            .look_key (key[n*4 +: 4]),
            .look_hit (slice_hit[n])
         );
      end
      assign hit[e] = &slice_hit;
   end
endmodule

// File: rtl/shift_cam.sv
module shift_cam #(
   parameter int DATA_W    = 8,
   parameter int NUM_BANKS = 2,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 0,
   localparam int ADDR_W   = 4 + BANK_W,
   localparam int DEPTH    = 16 * NUM_BANKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   input  logic              match_req,
   input  logic [DATA_W-1:0] match_key,
   output logic              hit_valid,
   output logic [DEPTH-1:0]  hit_vec,
   output logic              addr_valid,
   output logic              match_found,
   output logic [ADDR_W-1:0] match_addr
);
   if (DATA_W < 4 || (DATA_W % 4) != 0) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 4");
   end
   if (NUM_BANKS < 1 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two");
   end

   logic [3:0]        step;
   logic [ADDR_W-1:0] tgt_addr;
   logic [DATA_W-1:0] tgt_data;
   logic [DEPTH-1:0]  comb_vec;
   logic              accept;

   cam_load_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (wr_req),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .busy     (busy),
      .step     (step),
      .tgt_addr (tgt_addr),
      .tgt_data (tgt_data)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bank_ld;
      if (NUM_BANKS > 1) begin : g_sel
         assign bank_ld = busy && (tgt_addr[ADDR_W-1:4] == BANK_W'(b));
      end else begin : g_one
         assign bank_ld = busy;
      end
      cam_bank16 #(.DATA_W(DATA_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .ld_en   (bank_ld),
         .ld_slot (tgt_addr[3:0]),
         .ld_step (step),
         .ld_data (tgt_data),
         .key     (match_key),
         .hit     (comb_vec[b*16 +: 16])
      );
   end

   assign accept = match_req && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_valid <= 1'b0;
         hit_vec   <= '0;
      end else begin
         hit_valid <= accept;
         if (accept) hit_vec <= comb_vec;
      end
   end

   // Encoder: per-bank lowest position, then lowest bank that hit
   logic [NUM_BANKS-1:0] bank_any;
   logic [3:0]           bank_loc [NUM_BANKS];
   logic [ADDR_W-1:0]    enc_next;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_enc
      assign bank_any[b] = |hit_vec[b*16 +: 16];
      assign bank_loc[b] = shift_cam_pkg::lowest16(hit_vec[b*16 +: 16]);
   end

   if (NUM_BANKS == 1) begin : g_enc_flat
      assign enc_next = bank_loc[0];
   end else begin : g_enc_casc
      logic [BANK_W-1:0] sel;
      always_comb begin
         sel = '0;
         for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (bank_any[b]) sel = BANK_W'(b);
         end
      end
      assign enc_next = {sel, bank_loc[sel]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_valid  <= 1'b0;
         match_found <= 1'b0;
         match_addr  <= '0;
      end else begin
         addr_valid <= hit_valid;
         if (hit_valid) begin
            match_found <= |bank_any;
            match_addr  <= enc_next;
         end
      end
   end

   // R4: no search while a load runs
   p_no_match_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !hit_valid);
   // R6: the encoder follows one cycle behind the hit vector
   p_enc_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |=> addr_valid);
   // R8: found flag agrees with the vector it was encoded from
   p_found_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> (match_found == ($past(hit_vec) != '0)));
   // R7: the reported entry hit and no lower entry did
   p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && match_found) |->
         ((($past(hit_vec) >> match_addr) & DEPTH'(1)) != '0) &&
         (($past(hit_vec) & ((DEPTH'(1) << match_addr) - DEPTH'(1))) == '0));
   // R8: no hit reports index zero
   p_none_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && !match_found) |-> (match_addr == '0));
endmodule

// File: tb/sim_shift_cam.sv
module sim_shift_cam;
   localparam int DW    = 8;
   localparam int NB    = 2;
   localparam int AW    = 5;
   localparam int DEPTH = 32;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n;
   logic             wr_req;
   logic [AW-1:0]    wr_addr;
   logic [DW-1:0]    wr_data;
   logic             match_req;
   logic [DW-1:0]    match_key;
   logic             busy, hit_valid, addr_valid, match_found;
   logic [DEPTH-1:0] hit_vec;
   logic [AW-1:0]    match_addr;

   shift_cam #(.DATA_W(DW), .NUM_BANKS(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .match_req(match_req),
      .match_key(match_key), .hit_valid(hit_valid), .hit_vec(hit_vec),
      .addr_valid(addr_valid), .match_found(match_found),
      .match_addr(match_addr)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   logic [DW-1:0]    m_data [DEPTH];
   bit               m_ok   [DEPTH];
   int               m_busy;
   logic [AW-1:0]    m_waddr;
   logic [DW-1:0]    m_wdata;
   bit               m_hv, m_av, m_found;
   logic [DEPTH-1:0] m_vec;
   logic [AW-1:0]    m_addr;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin m_ok[i] = 0; m_data[i] = '0; end
         m_busy = 0; m_hv = 0; m_av = 0; m_found = 0; m_vec = '0; m_addr = '0;
      end else begin
         if (m_hv) begin
            m_found = (m_vec != '0);
            m_addr  = '0;
            for (int i = DEPTH - 1; i >= 0; i--) if (m_vec[i]) m_addr = AW'(i);
         end
         m_av = m_hv;
         if (match_req && m_busy == 0) begin
            for (int i = 0; i < DEPTH; i++) m_vec[i] = m_ok[i] && (m_data[i] == match_key);
            m_hv = 1;
         end else m_hv = 0;
         if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) begin m_data[m_waddr] = m_wdata; m_ok[m_waddr] = 1; end
         end else if (wr_req) begin
            m_busy = 16; m_waddr = wr_addr; m_wdata = wr_data;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 busy", 64'(busy), 64'(m_busy != 0));
         chk("R4 hit_valid", 64'(hit_valid), 64'(m_hv));
         if (m_hv) chk("R5 hit_vec", 64'(hit_vec), 64'(m_vec));
         chk("R6 addr_valid", 64'(addr_valid), 64'(m_av));
         if (m_av) begin
            chk("R8 match_found", 64'(match_found), 64'(m_found));
            chk("R7 R10 match_addr", 64'(match_addr), 64'(m_addr));
         end
      end
   end

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
      int n;
      wait_idle();
      wr_req = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_req = 0;
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk("R2 busy length", 64'(n), 64'd16);
   endtask

   task automatic lookup(logic [DW-1:0] k, bit ef, logic [AW-1:0] ea, string tag);
      wait_idle();
      match_req = 1; match_key = k;
      @(negedge clk);
      match_req = 0;
      @(negedge clk);
      chk({tag, " valid"}, 64'(addr_valid), 64'd1);
      chk({tag, " found"}, 64'(match_found), 64'(ef));
      chk({tag, " addr"},  64'(match_addr), 64'(ea));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 0; wr_req = 0; wr_addr = '0; wr_data = '0; match_req = 0; match_key = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 hit_valid", 64'(hit_valid), 64'd0);
      chk("R1 addr_valid", 64'(addr_valid), 64'd0);
      chk("R1 found", 64'(match_found), 64'd0);
      lookup(8'h00, 0, '0, "R1 empty");
      lookup(8'h5A, 0, '0, "R8 miss");

      do_write(5'd3, 8'h5A);
      lookup(8'h5A, 1, 5'd3, "R5 single");
      lookup(8'h5B, 0, '0, "R8 near miss");

      // R4: search requested during a load is held off
      wr_req = 1; wr_addr = 5'd20; wr_data = 8'h77;
      @(negedge clk);
      wr_req = 0; match_req = 1; match_key = 8'h77;
      @(negedge clk);
      chk("R4 held off", 64'(hit_valid), 64'd0);
      wait_idle();
      @(negedge clk);
      match_req = 0;
      chk("R4 after load", 64'(hit_valid), 64'd1);
      chk("R5 after load", 64'(hit_vec[20]), 64'd1);
      @(negedge clk);
      chk("R10 bank1 addr", 64'(match_addr), 64'd20);

      // R7: duplicates in both banks
      do_write(5'd7, 8'h77);
      lookup(8'h77, 1, 5'd7, "R7 duplicate");

      // R9: overwrite
      do_write(5'd7, 8'h11);
      lookup(8'h77, 1, 5'd20, "R9 old word gone");
      lookup(8'h11, 1, 5'd7, "R9 new word");

      // zero word stored at entry 0 vs empty entries
      do_write(5'd0, 8'h00);
      lookup(8'h00, 1, 5'd0, "R5 zero word");

      // R3: write request during load is ignored
      wait_idle();
      wr_req = 1; wr_addr = 5'd9; wr_data = 8'h33;
      @(negedge clk);
      wr_addr = 5'd10; wr_data = 8'h44;
      @(negedge clk);
      wr_req = 0;
      wait_idle();
      lookup(8'h44, 0, '0, "R3 ignored write");
      lookup(8'h33, 1, 5'd9, "R3 original write");

      // R11: search and write on the same edge
      wait_idle();
      wr_req = 1; wr_addr = 5'd2; wr_data = 8'hC3;
      match_req = 1; match_key = 8'hC3;
      @(negedge clk);
      wr_req = 0; match_req = 0;
      @(negedge clk);
      chk("R11 old contents", 64'(match_found), 64'd0);
      lookup(8'hC3, 1, 5'd2, "R11 after load");

      // random mix over a small value set
      for (int r = 0; r < 60; r++) begin
         if ($urandom_range(1, 0) == 1)
            do_write(AW'($urandom_range(DEPTH - 1, 0)), DW'($urandom_range(7, 0)));
         wait_idle();
         match_req = 1; match_key = DW'($urandom_range(7, 0));
         @(negedge clk);
         match_req = 0;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule